// File: doc/BRIEF.md
# Status Register Write Unit

This block holds the current and saved program status words of a processor core and applies a move-to-status-register operation to them. Each operation carries a 32-bit source word and a select bit that chooses the current word or the saved word. The operating mode in the low five bits of the current word decides which bytes of the source are taken. A select of the saved word in an unprivileged mode does nothing. A write to the current word from a privileged mode also asks the surrounding core to switch register banks to the new mode, and that switch must not save the old current word.

The condition flags, the two interrupt enables and a fast-interrupt pending line are decoded from the stored current word. The bank switch itself is done outside this block, which only emits a one-cycle request with the target mode. An operation is applied at the clock edge that samples it. All outputs except the pending line are registered.

Top module: `psr_write_unit`

## Requirements
- R1: A saved-word write (wr_spsr_i=1) when the current mode code (cpsr_o[4:0]) is greater than 0x10 and less than 0x1F replaces saved bits 31:24 and 7:0 from the source and keeps saved bits 23:8.
- R2: A saved-word write when the current mode code is 0x10 or 0x1F leaves spsr_o and cpsr_o unchanged.
- R3: A current-word write (wr_spsr_i=0) always replaces bits 31:24 of cpsr_o from the source and keeps bits 23:8.
- R4: A current-word write replaces cpsr_o bits 7:0 from the source only when the current mode code is above 0x10. In mode 0x10 those bits are kept.
- R5: Bit 4 of cpsr_o is 1 at all times, whatever the source bit 4 is.
- R6: A current-word write while the mode code is above 0x10 raises mode_chg_o for exactly the one cycle after the write edge, with mode_new_o equal to the new cpsr_o[4:0]; spsr_o is not changed by it. A current-word write in mode 0x10 raises no request.
- R7: flags_o equals cpsr_o[31:28]; irq_en_o is the inverse of cpsr_o bit 7; fiq_en_o is the inverse of cpsr_o bit 6.
- R8: fiq_pend_o is high exactly when fiq_req_i is high and fiq_en_o is high.
- R9: After reset cpsr_o is 0x00000053 (mode 0x13, fast interrupts masked, interrupts enabled), spsr_o is 0 and mode_chg_o is 0.
- R10: With wr_en_i low, cpsr_o and spsr_o hold their values regardless of wr_data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Apply a write on this edge |
| wr_spsr_i | input | 1 | 1 selects the saved word, 0 the current word |
| wr_data_i | input | 32 | Source word |
| fiq_req_i | input | 1 | Fast interrupt request line |
| cpsr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved status word |
| flags_o | output | 4 | N, Z, C, V flags |
| irq_en_o | output | 1 | Normal interrupt enabled |
| fiq_en_o | output | 1 | Fast interrupt enabled |
| fiq_pend_o | output | 1 | Fast interrupt request gated by its enable |
| mode_chg_o | output | 1 | One-cycle bank switch request, no state save |
| mode_new_o | output | 5 | Target mode of the request |

## Verification
A privileged current-word write can set the fast-interrupt mask bit and change mode in one step. When that happens, the bank switch request and the fall of the pending line land in the same cycle. The bench holds fiq_req_i high through the whole write sequence and includes one write that both leaves supervisor mode and masks fast interrupts. In the cycle after that edge it checks that mode_chg_o is high with the new mode and that fiq_pend_o has dropped. Writes before it leave the mask clear, so they must show a request with the pending line still high.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned MODE_W   = 5;
  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;
  localparam int unsigned FLAG_MSB = 31;
  localparam int unsigned FLAG_W   = 4;
  localparam int unsigned IRQ_BIT  = 7;
  localparam int unsigned FIQ_BIT  = 6;
  localparam int unsigned FIX_BIT  = 4;

  function automatic logic mode_priv(input logic [MODE_W-1:0] m);
    return m > MODE_USR;
  endfunction

  function automatic logic mode_banked(input logic [MODE_W-1:0] m);
    return (m > MODE_USR) && (m < MODE_SYS);
  endfunction
endpackage

// File: rtl/psr_merge.sv
module psr_merge
  import psr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned TOP_W  = 8
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] cpsr_i,
  input  logic [DATA_W-1:0] spsr_i,
  input  logic              ctrl_wr_i,
  output logic [DATA_W-1:0] cpsr_nxt_o,
  output logic [DATA_W-1:0] spsr_nxt_o
);
  localparam int unsigned TOP_LSB = DATA_W - TOP_W;

  logic [DATA_W-1:0] cpsr_raw;

  // byte lanes: top from source, middle kept, control byte per lane rule
  for (genvar b = 0; b < DATA_W; b++) begin : g_lane
    if (b >= TOP_LSB) begin : g_top
      assign cpsr_raw[b]   = src_i[b];
      assign spsr_nxt_o[b] = src_i[b];
    end else if (b < CTRL_W) begin : g_ctrl
      assign cpsr_raw[b]   = ctrl_wr_i ? src_i[b] : cpsr_i[b];
      assign spsr_nxt_o[b] = src_i[b];
    end else begin : g_mid
      assign cpsr_raw[b]   = cpsr_i[b];
      assign spsr_nxt_o[b] = spsr_i[b];
    end
  end

  always_comb begin
    cpsr_nxt_o          = cpsr_raw;
    cpsr_nxt_o[FIX_BIT] = 1'b1;
  end
endmodule

// File: rtl/psr_regs.sv
module psr_regs
  import psr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter logic [DATA_W-1:0] RST_CPSR = 32'h0000_0053,
  parameter logic [DATA_W-1:0] RST_SPSR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpsr_we_i,
  input  logic              spsr_we_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] cpsr_nxt_i,
  input  logic [DATA_W-1:0] spsr_nxt_i,
  output logic [DATA_W-1:0] cpsr_q_o,
  output logic [DATA_W-1:0] spsr_q_o,
  output logic              req_q_o,
  output logic [MODE_W-1:0] mode_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpsr_q_o <= RST_CPSR;
      spsr_q_o <= RST_SPSR;
      req_q_o  <= 1'b0;
      mode_q_o <= RST_CPSR[MODE_W-1:0];
    end else begin
      if (cpsr_we_i) cpsr_q_o <= cpsr_nxt_i;
      if (spsr_we_i) spsr_q_o <= spsr_nxt_i;
      req_q_o <= req_i;
      if (req_i) mode_q_o <= cpsr_nxt_i[MODE_W-1:0];
    end
  end
endmodule

// File: rtl/psr_decode.sv
module psr_decode
  import psr_pkg::*;
(
  input  logic [FLAG_W-1:0] flag_bits_i,
  input  logic              irq_mask_i,
  input  logic              fiq_mask_i,
  input  logic              fiq_req_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_en_o,
  output logic              fiq_en_o,
  output logic              fiq_pend_o
);
  assign flags_o    = flag_bits_i;
  assign irq_en_o   = ~irq_mask_i;
  assign fiq_en_o   = ~fiq_mask_i;
  assign fiq_pend_o = fiq_req_i & ~fiq_mask_i;
endmodule

// File: rtl/psr_write_unit.sv
module psr_write_unit
  import psr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] RST_CPSR = 32'h0000_0053
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_spsr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fiq_req_i,
  output logic [DATA_W-1:0] cpsr_o,
  output logic [DATA_W-1:0] spsr_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_en_o,
  output logic              fiq_en_o,
  output logic              fiq_pend_o,
  output logic              mode_chg_o,
  output logic [MODE_W-1:0] mode_new_o
);
  logic [DATA_W-1:0] cpsr_q, spsr_q, cpsr_nxt, spsr_nxt;
  logic [MODE_W-1:0] cur_mode;
  logic              priv, banked, cpsr_we, spsr_we, req;

  assign cur_mode = cpsr_q[MODE_W-1:0];
  assign priv     = mode_priv(cur_mode);
  assign banked   = mode_banked(cur_mode);
  assign cpsr_we  = wr_en_i & ~wr_spsr_i;
  assign spsr_we  = wr_en_i & wr_spsr_i & banked;
  assign req      = cpsr_we & priv;

  psr_merge #(.DATA_W(DATA_W)) i_merge (
    .src_i      (wr_data_i),
    .cpsr_i     (cpsr_q),
    .spsr_i     (spsr_q),
    .ctrl_wr_i  (priv),
    .cpsr_nxt_o (cpsr_nxt),
    .spsr_nxt_o (spsr_nxt)
  );

  psr_regs #(.DATA_W(DATA_W), .RST_CPSR(RST_CPSR)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpsr_we_i  (cpsr_we),
    .spsr_we_i  (spsr_we),
    .req_i      (req),
    .cpsr_nxt_i (cpsr_nxt),
    .spsr_nxt_i (spsr_nxt),
    .cpsr_q_o   (cpsr_q),
    .spsr_q_o   (spsr_q),
    .req_q_o    (mode_chg_o),
    .mode_q_o   (mode_new_o)
  );

  psr_decode i_decode (
    .flag_bits_i (cpsr_q[FLAG_MSB -: FLAG_W]),
    .irq_mask_i  (cpsr_q[IRQ_BIT]),
    .fiq_mask_i  (cpsr_q[FIQ_BIT]),
    .fiq_req_i   (fiq_req_i),
    .flags_o     (flags_o),
    .irq_en_o    (irq_en_o),
    .fiq_en_o    (fiq_en_o),
    .fiq_pend_o  (fiq_pend_o)
  );

  assign cpsr_o = cpsr_q;
  assign spsr_o = spsr_q;
endmodule

// File: rtl/psr_write_unit_chk.sv
module psr_write_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        wr_spsr_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] cpsr_o,
  input logic [31:0] spsr_o,
  input logic        mode_chg_o,
  input logic [4:0]  mode_new_o
);
  AST_SPSR_MID_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_spsr_i && cpsr_o[4:0] > 5'h10 && cpsr_o[4:0] < 5'h1F
    |=> spsr_o[23:8] == $past(spsr_o[23:8]) && spsr_o[7:0] == $past(wr_data_i[7:0])); // R1
  AST_SPSR_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_spsr_i && (cpsr_o[4:0] == 5'h10 || cpsr_o[4:0] == 5'h1F)
    |=> $stable(spsr_o) && $stable(cpsr_o)); // R2
  AST_CPSR_TOP_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_spsr_i
    |=> cpsr_o[31:24] == $past(wr_data_i[31:24]) && cpsr_o[23:8] == $past(cpsr_o[23:8])); // R3
  AST_USER_CTRL_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_spsr_i && cpsr_o[4:0] == 5'h10
    |=> cpsr_o[7:0] == $past(cpsr_o[7:0])); // R4
  AST_FIXED_BIT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpsr_o[4]); // R5
  AST_REQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> $past(wr_en_i) && !$past(wr_spsr_i) && ($past(cpsr_o[4:0]) > 5'h10)); // R6
  AST_REQ_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> mode_new_o == cpsr_o[4:0]); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cpsr_o) && $stable(spsr_o)); // R10
endmodule

bind psr_write_unit psr_write_unit_chk i_psr_write_unit_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_spsr_i  (wr_spsr_i),
  .wr_data_i  (wr_data_i),
  .cpsr_o     (cpsr_o),
  .spsr_o     (spsr_o),
  .mode_chg_o (mode_chg_o),
  .mode_new_o (mode_new_o)
);

// File: tb/test_psr_write_unit.sv
module test_psr_write_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 7;

  typedef struct packed {
    bit        sp;
    bit [31:0] data;
    bit [31:0] cpsr;
    bit [31:0] spsr;
    bit        chg;
    bit [4:0]  mode;
  } vec_t;

  // sequence starts from reset state cpsr=0x53 (mode 0x13)
  localparam vec_t VECS [N_VEC] = '{
    '{1'b1, 32'hA5B6C7D8, 32'h00000053, 32'hA50000D8, 1'b0, 5'h00}, // R1 banked saved write
    '{1'b0, 32'hF1234592, 32'hF1000092, 32'hA50000D8, 1'b1, 5'h12}, // R3 R4 R6 to 0x12
    '{1'b1, 32'h12345678, 32'hF1000092, 32'h12000078, 1'b0, 5'h00}, // R1 in 0x12
    '{1'b0, 32'h60FFFF03, 32'h60000013, 32'h12000078, 1'b1, 5'h13}, // R5 bit 4 forced
    '{1'b0, 32'h000000D0, 32'h000000D0, 32'h12000078, 1'b1, 5'h10}, // R6 R8 mask fiq + switch
    '{1'b0, 32'h9000001F, 32'h900000D0, 32'h12000078, 1'b0, 5'h00}, // R4 user keeps ctrl
    '{1'b1, 32'hFFFFFFFF, 32'h900000D0, 32'h12000078, 1'b0, 5'h00}  // R2 user saved write
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_spsr_i = 1'b0, fiq_req_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] cpsr_o, spsr_o;
  logic [3:0]  flags_o;
  logic        irq_en_o, fiq_en_o, fiq_pend_o, mode_chg_o;
  logic [4:0]  mode_new_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_write_unit i_psr_write_unit (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_spsr_i(wr_spsr_i),
    .wr_data_i(wr_data_i), .fiq_req_i(fiq_req_i), .cpsr_o(cpsr_o), .spsr_o(spsr_o),
    .flags_o(flags_o), .irq_en_o(irq_en_o), .fiq_en_o(fiq_en_o),
    .fiq_pend_o(fiq_pend_o), .mode_chg_o(mode_chg_o), .mode_new_o(mode_new_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input logic [31:0] ec, input logic [31:0] es);
    chk({tag, " R3 R4 cpsr"}, cpsr_o, ec);
    chk({tag, " R1 R2 spsr"}, spsr_o, es);
    chk({tag, " R5 bit4"}, {31'd0, cpsr_o[4]}, 32'd1);
    chk({tag, " R7 flags"}, {28'd0, flags_o}, {28'd0, ec[31:28]});
    chk({tag, " R7 irq_en"}, {31'd0, irq_en_o}, {31'd0, ~ec[7]});
    chk({tag, " R7 fiq_en"}, {31'd0, fiq_en_o}, {31'd0, ~ec[6]});
    chk({tag, " R8 fiq_pend"}, {31'd0, fiq_pend_o}, {31'd0, fiq_req_i & ~ec[6]});
  endtask

  task automatic do_write(input bit sp, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_spsr_i = sp; wr_data_i = d;
    @(posedge clk); #1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    fiq_req_i = 1'b1;
    repeat (2) @(negedge clk);
    // R9 reset state
    chk("R9 cpsr", cpsr_o, 32'h00000053);
    chk("R9 spsr", spsr_o, 32'h0);
    chk("R9 chg", {31'd0, mode_chg_o}, 32'd0);
    chk("R8 masked at reset", {31'd0, fiq_pend_o}, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      wr_en_i = 1'b1; wr_spsr_i = VECS[i].sp; wr_data_i = VECS[i].data;
      @(posedge clk); #1;
      chk_state($sformatf("vec%0d", i), VECS[i].cpsr, VECS[i].spsr);
      chk("R6 chg", {31'd0, mode_chg_o}, {31'd0, VECS[i].chg});
      if (VECS[i].chg) chk("R6 mode", {27'd0, mode_new_o}, {27'd0, VECS[i].mode});
      @(negedge clk);
      wr_en_i = 1'b0;
      wr_data_i = 32'h0F0F_F0F0;
      @(posedge clk); #1;
      chk("R6 one cycle", {31'd0, mode_chg_o}, 32'd0);
      chk("R10 hold cpsr", cpsr_o, VECS[i].cpsr);
      chk("R10 hold spsr", spsr_o, VECS[i].spsr);
    end

    // R8 pending follows request line combinationally
    do_reset();
    do_write(1'b0, 32'h00000013);   // clear fiq mask, stay 0x13
    #1;
    chk("R8 pend high", {31'd0, fiq_pend_o}, 32'd1);
    fiq_req_i = 1'b0; #1;
    chk("R8 pend low", {31'd0, fiq_pend_o}, 32'd0);

    // system mode: saved write ignored, control byte writable
    do_reset();
    do_write(1'b0, 32'h0000001F);
    chk_state("sys", 32'h0000001F, 32'h0);
    @(negedge clk);
    wr_en_i = 1'b1; wr_spsr_i = 1'b1; wr_data_i = 32'hDEADBEEF;
    @(posedge clk); #1;
    chk("R2 sys spsr", spsr_o, 32'h0);
    chk("R2 sys cpsr", cpsr_o, 32'h0000001F);
    @(negedge clk);
    wr_spsr_i = 1'b0; wr_data_i = 32'h4000005F;
    @(posedge clk); #1;
    chk("R4 sys ctrl", cpsr_o, 32'h4000005F);
    chk("R6 sys chg", {31'd0, mode_chg_o}, 32'd1);
    chk("R6 sys mode", {27'd0, mode_new_o}, 32'h1F);
    // back-to-back write: second pulse, spsr untouched by switch
    @(negedge clk);
    wr_data_i = 32'h80000051;
    @(posedge clk); #1;
    chk("R6 b2b chg", {31'd0, mode_chg_o}, 32'd1);
    chk("R6 b2b mode", {27'd0, mode_new_o}, 32'h11);
    chk("R6 spsr kept", spsr_o, 32'h0);
    @(negedge clk);
    wr_en_i = 1'b0;
    @(posedge clk); #1;
    chk("R6 b2b end", {31'd0, mode_chg_o}, 32'd0);

    // reset while state is non-default
    do_reset();
    #1;
    chk("R9 re-reset cpsr", cpsr_o, 32'h00000053);
    finish_run();
  end
endmodule